// File: doc/BRIEF.md
# GPIO Set/Clear Output Stage

This block drives four general-purpose pins from configuration writes. Software never writes a pin level directly. One byte of the configuration word carries two nibbles. A 1 in the clear nibble pulls the matching pin low, and a 1 in the set nibble pulls it high. A 0 in either nibble leaves the pin alone, so several agents can change different pins without a read-modify-write.

Each pin has a direction bit. A pin marked bidirectional has its output enable asserted and follows the set and clear requests. A pin marked input-only is never driven, and writes leave its stored level untouched. The new level shows on the pin outputs in the cycle after the clock edge that accepts the write. Reading the register returns the nibbles as they were last written.

Top module: `gpio_setclr_out`

## Requirements
- R1: A synchronous active-high reset clears `pin_out`, `pin_oe` and the whole of `rd_data` to 0.
- R2: A 1 in bit 8+i of an accepted write drives pin i low. The new level is visible after the clock edge that samples the write.
- R3: A 1 in bit 12+i of an accepted write drives pin i high. The new level is visible after the clock edge that samples the write.
- R4: When bit 8+i and bit 12+i are both 1 in one write, pin i goes low, because clear wins.
- R5: A 0 in bit 8+i or bit 12+i of an accepted write leaves the level of pin i unchanged.
- R6: A write never changes the stored level of a pin whose `pin_bidir` bit is 0, and that pin's `pin_oe` bit stays 0.
- R7: `pin_oe[i]` equals `pin_bidir[i]` as it was sampled at the previous clock edge.
- R8: `rd_data[11:8]` and `rd_data[15:12]` return the clear and set nibbles of the last accepted write. All other bits of `rd_data` read 0.
- R9: A write is accepted only when `cfg_be[1]` is 1. Any other write changes neither the pins nor `rd_data`.
- R10: Without an accepted write, `pin_out` holds its last level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe for this register |
| cfg_wdata | input | 32 | Write data. Bits 11:8 are the clear nibble and bits 15:12 are the set nibble |
| cfg_be | input | 4 | Byte enables. Bit 1 covers bits 15:8 |
| pin_bidir | input | 4 | Per-pin direction: 1 = bidirectional, 0 = input-only |
| pin_out | output | 4 | Per-pin output level |
| pin_oe | output | 4 | Per-pin output enable |
| rd_data | output | 32 | Register read value |

## Verification
The stimulus runs in several passes. An all-ones set nibble followed by a sparse clear nibble shows that each pin responds only to its own bit. A write with overlapping set and clear bits shows that clear has priority. An all-zero write is sent, and a write with the wrong byte enable is sent, to separate "no request" from "no write". A run with half the pins input-only checks that the direction mask gates both the stored level and the output enable. Flipping the direction afterwards exposes the level those input-only pins kept.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

  typedef enum logic [1:0] {
    DRV_HOLD = 2'd0,
    DRV_LOW  = 2'd1,
    DRV_HIGH = 2'd2
  } drv_act_e;

  // Clear has priority over set.
  function automatic drv_act_e decode_act(input logic clr_bit, input logic set_bit);
    if (clr_bit)      return DRV_LOW;
    else if (set_bit) return DRV_HIGH;
    else              return DRV_HOLD;
  endfunction

endpackage

// File: rtl/gpio_sc_field.sv
module gpio_sc_field #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_val;
  end

endmodule

// File: rtl/gpio_sc_pin.sv
module gpio_sc_pin
  import gpio_sc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bidir,
  input  logic apply,
  input  logic clr_bit,
  input  logic set_bit,
  output logic level,
  output logic oe
);

  drv_act_e act;

  always_comb begin
    act = DRV_HOLD;
    if (apply && bidir) act = decode_act(clr_bit, set_bit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      oe    <= 1'b0;
    end else begin
      oe <= bidir;
      case (act)
        DRV_LOW:  level <= 1'b0;
        DRV_HIGH: level <= 1'b1;
        default:  level <= level;
      endcase
    end
  end

endmodule

// File: rtl/gpio_setclr_out.sv
module gpio_setclr_out #(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 32,
  parameter int CLR_LSB  = 8,
  parameter int SET_LSB  = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic [DATA_W/8-1:0] cfg_be,
  input  logic [NUM_PINS-1:0] pin_bidir,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [DATA_W-1:0]   rd_data
);

  localparam int BE_CLR = CLR_LSB / 8;
  localparam int BE_SET = SET_LSB / 8;

  logic                wr_hit;
  logic [NUM_PINS-1:0] clr_req, set_req;
  logic [NUM_PINS-1:0] clr_q, set_q;

  assign wr_hit  = cfg_wr && cfg_be[BE_CLR] && cfg_be[BE_SET];
  assign clr_req = cfg_wdata[CLR_LSB +: NUM_PINS];
  assign set_req = cfg_wdata[SET_LSB +: NUM_PINS];

  gpio_sc_field #(.W(NUM_PINS)) u_clr_fld (
    .clk(clk), .rst(rst), .wr_en(wr_hit), .wr_val(clr_req), .q(clr_q)
  );

  gpio_sc_field #(.W(NUM_PINS)) u_set_fld (
    .clk(clk), .rst(rst), .wr_en(wr_hit), .wr_val(set_req), .q(set_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_sc_pin u_pin (
      .clk    (clk),
      .rst    (rst),
      .bidir  (pin_bidir[i]),
      .apply  (wr_hit),
      .clr_bit(clr_req[i]),
      .set_bit(set_req[i]),
      .level  (pin_out[i]),
      .oe     (pin_oe[i])
    );
  end

  always_comb begin
    rd_data = '0;
    rd_data[CLR_LSB +: NUM_PINS] = clr_q;
    rd_data[SET_LSB +: NUM_PINS] = set_q;
  end

endmodule

// File: rtl/gpio_setclr_out_chk.sv
module gpio_setclr_out_chk #(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 32,
  parameter int CLR_LSB  = 8,
  parameter int SET_LSB  = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_wr,
  input logic [DATA_W-1:0]   cfg_wdata,
  input logic [DATA_W/8-1:0] cfg_be,
  input logic [NUM_PINS-1:0] pin_bidir,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [DATA_W-1:0]   rd_data
);

  logic                hit;
  logic [NUM_PINS-1:0] cv, sv, low_m, high_m;

  assign hit    = cfg_wr && cfg_be[CLR_LSB/8] && cfg_be[SET_LSB/8];
  assign cv     = cfg_wdata[CLR_LSB +: NUM_PINS];
  assign sv     = cfg_wdata[SET_LSB +: NUM_PINS];
  assign low_m  = cv & pin_bidir;
  assign high_m = sv & ~cv & pin_bidir;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && rd_data == '0));

  a_r2_r4_clear_low: assert property (@(posedge clk) disable iff (rst)
    hit |=> ((pin_out & $past(low_m)) == '0));

  a_r3_set_high: assert property (@(posedge clk) disable iff (rst)
    hit |=> ((pin_out & $past(high_m)) == $past(high_m)));

  a_r5_r6_untouched_hold: assert property (@(posedge clk) disable iff (rst)
    hit |=> (((pin_out ^ $past(pin_out)) & ~($past(low_m) | $past(high_m))) == '0));

  a_r7_oe_follows_dir: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_oe == $past(pin_bidir)));

  a_r8_readback: assert property (@(posedge clk) disable iff (rst)
    hit |=> (rd_data[CLR_LSB +: NUM_PINS] == $past(cv) &&
             rd_data[SET_LSB +: NUM_PINS] == $past(sv)));

  a_r9_r10_no_write_hold: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(pin_out) && $stable(rd_data)));

endmodule

bind gpio_setclr_out gpio_setclr_out_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .CLR_LSB(CLR_LSB), .SET_LSB(SET_LSB)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
  .pin_bidir(pin_bidir), .pin_out(pin_out), .pin_oe(pin_oe), .rd_data(rd_data)
);

// File: tb/gpio_setclr_out_tb.sv
`timescale 1ns/1ps
module gpio_setclr_out_tb;

  typedef struct {
    logic [3:0]  po;
    logic [3:0]  oe;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [3:0]  pin_bidir = '0;
  logic [3:0]  pin_out, pin_oe;
  logic [31:0] rd_data;

  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  exp_t sb[$];

  logic [3:0] m_lvl = '0, m_clr = '0, m_set = '0;

  always #4 clk = ~clk;

  gpio_setclr_out u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
    .pin_bidir(pin_bidir), .pin_out(pin_out), .pin_oe(pin_oe), .rd_data(rd_data)
  );

  function automatic logic [31:0] m_rd();
    return {16'h0, m_set, m_clr, 8'h0};
  endfunction

  task automatic check(string tag, logic [3:0] po, logic [3:0] oe, logic [31:0] rd);
    n_run++;
    if (pin_out !== po || pin_oe !== oe || rd_data !== rd) begin
      n_fail++;
      $display("FAIL %s: out=%h oe=%h rd=%h expected out=%h oe=%h rd=%h",
               tag, pin_out, pin_oe, rd_data, po, oe, rd);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(bit wr, logic [31:0] d, logic [3:0] be, logic [3:0] dir, string tag);
    exp_t e;
    @(negedge clk);
    cfg_wr = wr; cfg_wdata = d; cfg_be = be; pin_bidir = dir;
    if (wr && be[1]) begin
      m_clr = d[11:8];
      m_set = d[15:12];
      for (int i = 0; i < 4; i++)
        if (dir[i]) begin
          if (m_clr[i])      m_lvl[i] = 1'b0;
          else if (m_set[i]) m_lvl[i] = 1'b1;
        end
    end
    e.po = m_lvl; e.oe = dir; e.rd = m_rd(); e.tag = tag;
    @(posedge clk);
    #1;
    sb.push_back(e);
    cfg_wr = 1'b0;
  endtask

  // Monitor: compares queued expectations away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, e.po, e.oe, e.rd);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_wr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 4'h0, 4'h0, 32'h0);
    m_lvl = '0; m_clr = '0; m_set = '0;
    rst = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    drive(1, 32'h0000_F000, 4'hF, 4'hF, "R3 set all");
    drive(1, 32'h0000_0500, 4'h2, 4'hF, "R2 clear 0101 / R8 readback");
    drive(1, 32'h0000_3300, 4'hF, 4'hF, "R4 clear beats set");
    drive(1, 32'h0000_0000, 4'hF, 4'hF, "R5 zero write holds");
    drive(1, 32'h0000_F0F0, 4'hD, 4'hF, "R9 byte enable off");
    drive(1, 32'h0000_0300, 4'h2, 4'hF, "R2 clear low pins");
    drive(1, 32'h0000_F000, 4'h2, 4'h3, "R6 input-only pins kept");
    drive(0, 32'h0000_0F00, 4'hF, 4'h3, "R10 idle hold");
    drive(0, 32'h0000_0000, 4'h0, 4'hF, "R7 oe follows dir");
    drive(1, 32'hFFFF_50FF, 4'hF, 4'hF, "R8 other bits read 0");
    drive(0, 32'h0, 4'h0, 4'h5, "R7 oe partial");
    drive(0, 32'h0, 4'h0, 4'h5, "R10 second idle");
    drive(1, 32'h0000_0F00, 4'h2, 4'h0, "R6 all input-only");
    drive(0, 32'h0, 4'h0, 4'hF, "R6 level revealed");
    @(negedge clk);
    @(negedge clk);
    do_reset();
    drive(0, 32'h0, 4'h0, 4'h0, "R1 after reset idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule